// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Flag Timing

This block buffers 36-bit words between a write port and a read port whose clocks may be unrelated or may be the same clock. Read and write pointers cross between the two clock domains in Gray code. Each status flag is formed in the domain that consumes it.

A master reset selects how the read side behaves. In classic mode a word is fetched by asserting the read enable while the buffer is not empty, and the word appears one read-clock edge later. The read flag means "empty" and the write flag means "full". In fall-through mode the oldest stored word is placed on the read data output without any read enable. The read flag then means "output holds a valid word" and the write flag means "space available". Asserting the read enable consumes the presented word.

Almost-empty and almost-full flags compare the fill level against two offsets. Each offset gets one of three defaults at master reset. Either offset can later be reloaded through the write data bus, in parallel in one cycle or serially one bit per cycle. A partial reset discards the stored words but keeps the mode and both offsets.

Top module: `xfifo_top`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, bit-exact over all 36 bits. The buffer holds DEPTH words, where DEPTH is 256, 512 or 1024.
- R2: In classic mode (modeSel=0 at master reset), rdFlag is 1 exactly when no word is stored. wrFlag is 1 exactly when DEPTH words are stored. A read enable while rdFlag=0 places the oldest word on rdData after that rising read-clock edge.
- R3: In fall-through mode (modeSel=1 at master reset), the first word written into an empty buffer appears on rdData with rdFlag=1 without any read enable. The word stays there until a read-enable edge consumes it. wrFlag=1 means space is available.
- R4: A write while full and a read while empty have no effect: no word is added or lost and the pointers do not move.
- R5: almostEmpty is 1 when the stored word count is at or below the empty offset. In fall-through mode the stored count includes the word held on rdData.
- R6: almostFull is 1 when DEPTH minus the stored word count (memory array only) is at or below the full offset.
- R7: At master reset, offSel picks the default for both offsets: 0 gives 8, 1 gives 16, and 2 or 3 gives 64.
- R8: While offLoad=1, no word is written. With offSerial=0, one write-clock edge loads the empty offset from wrData[AW-1:0] and the full offset from wrData[16+AW-1:16]. With offSerial=1, each edge shifts wrData[0] into the LSB of the 2·AW-bit register {full offset, empty offset}, so the last bit shifted in lands in the empty offset's LSB. AW is log2(DEPTH).
- R9: partialRst empties the buffer and keeps the timing mode and both offsets.
- R10: masterRst empties the buffer and reloads the timing mode and offset defaults from modeSel and offSel.
- R11: With both ports on the same clock, a write and a read on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| masterRst | input | 1 | Active-high reset; empties buffer and captures mode and offset defaults |
| partialRst | input | 1 | Active-high reset; empties buffer only |
| modeSel | input | 1 | 0 classic, 1 fall-through; sampled during masterRst |
| offSel | input | 2 | Default offset code; sampled during masterRst |
| offLoad | input | 1 | Offset load strobe (write clock) |
| offSerial | input | 1 | 1 serial shift, 0 parallel load |
| wrEn | input | 1 | Write enable |
| wrData | input | 36 | Write data; also carries offset values during a load |
| wrFlag | output | 1 | Full (classic) or input-ready (fall-through) |
| almostFull | output | 1 | Free space at or below full offset |
| rdEn | input | 1 | Read enable |
| rdData | output | 36 | Read data |
| rdFlag | output | 1 | Empty (classic) or output-ready (fall-through) |
| almostEmpty | output | 1 | Stored count at or below empty offset |

## Verification
Several properties are checked on every cycle. The write pointer holds still when a write meets a full buffer, and the read pointer holds still on a read of an empty one. Stored occupancy never exceeds DEPTH. A synchronised Gray pointer changes at most one bit per edge. Full implies almost-full, and an empty read side implies almost-empty. In fall-through mode a presented word stays unchanged until it is consumed.

The bench scenarios are needed for the rest. Only they show end-to-end word order, the exact almost-flag thresholds for defaults and for loaded offsets, and the serial bit order. They also show that a partial reset keeps configuration while a master reset restores it.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  localparam int DATA_W   = 36;
  localparam int HI_FIELD = 16;  // LSB of the full-offset field on the data bus

  typedef struct packed {
    logic wrPush;  // store wrData at the write address
    logic rdLoad;  // fetch memory word into the output register
  } fifoStrb_t;

  function automatic int dfltOffset(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return 64;
    endcase
  endfunction
endpackage

// File: rtl/xfifo_gsync.sv
module xfifo_gsync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/xfifo_ctrl.sv
module xfifo_ctrl
  import xfifo_pkg::*;
#(
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          masterRst,
  input  logic          partialRst,
  input  logic          modeSel,
  input  logic [1:0]    offSel,
  input  logic          offLoad,
  input  logic          offSerial,
  input  logic [AW-1:0] offLoData,
  input  logic [AW-1:0] offHiData,
  input  logic          wrEn,
  input  logic          rdEn,
  output fifoStrb_t     strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fwftOn,
  output logic          wrFlag,
  output logic          almostFull,
  output logic          rdFlag,
  output logic          almostEmpty
);
  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic rstAll;
  assign rstAll = masterRst | partialRst;

  // configuration: captured by master reset only
  logic          fwftMode;
  logic [AW-1:0] aeOff, afOff;

  always_ff @(posedge wrClk) begin
    if (masterRst) begin
      fwftMode <= modeSel;
      aeOff    <= AW'(dfltOffset(offSel));
      afOff    <= AW'(dfltOffset(offSel));
    end else if (offLoad) begin
      if (offSerial) {afOff, aeOff} <= {afOff[AW-2:0], aeOff, offLoData[0]};
      else begin
        aeOff <= offLoData;
        afOff <= offHiData;
      end
    end
  end
  assign fwftOn = fwftMode;

  // write domain
  logic [PW-1:0] wrPtr, wrGray, rdGraySync, rdPtrW, wrUsed, wrFree;
  logic          full, wrPush;

  assign rdPtrW = gray2bin(rdGraySync);
  assign wrUsed = wrPtr - rdPtrW;
  assign wrFree = PW'(DEPTH) - wrUsed;
  assign full   = (wrUsed == PW'(DEPTH));
  assign wrPush = wrEn && !offLoad && !full;

  always_ff @(posedge wrClk or posedge rstAll) begin
    if (rstAll) begin
      wrPtr  <= '0;
      wrGray <= '0;
    end else if (wrPush) begin
      wrPtr  <= wrPtr + PW'(1);
      wrGray <= bin2gray(wrPtr + PW'(1));
    end
  end

  assign wrAddr     = wrPtr[AW-1:0];
  assign wrFlag     = fwftMode ? !full : full;
  assign almostFull = (wrFree <= {1'b0, afOff});

  // read domain
  logic [PW-1:0] rdPtr, rdGray, wrGraySync, wrPtrR;
  logic [PW:0]   rdCount;
  logic          memEmpty, outValid, rdLoad;

  assign wrPtrR   = gray2bin(wrGraySync);
  assign memEmpty = (wrPtrR == rdPtr);

  always_comb begin
    if (fwftMode) rdLoad = !memEmpty && (!outValid || rdEn);
    else          rdLoad = rdEn && !memEmpty;
    strb.wrPush = wrPush;
    strb.rdLoad = rdLoad;
  end

  always_ff @(posedge rdClk or posedge rstAll) begin
    if (rstAll) begin
      rdPtr    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else begin
      if (rdLoad) begin
        rdPtr  <= rdPtr + PW'(1);
        rdGray <= bin2gray(rdPtr + PW'(1));
      end
      if (!fwftMode)   outValid <= 1'b0;
      else if (rdLoad) outValid <= 1'b1;
      else if (rdEn)   outValid <= 1'b0;
    end
  end

  assign rdAddr      = rdPtr[AW-1:0];
  assign rdCount     = {1'b0, wrPtrR - rdPtr} + (PW+1)'(fwftMode && outValid);
  assign almostEmpty = (rdCount <= (PW+1)'(aeOff));
  assign rdFlag      = fwftMode ? outValid : memEmpty;

  xfifo_gsync #(.W(PW)) wrToRd_i (.clk(rdClk), .rst(rstAll), .din(wrGray), .dout(wrGraySync));
  xfifo_gsync #(.W(PW)) rdToWr_i (.clk(wrClk), .rst(rstAll), .din(rdGray), .dout(rdGraySync));

  // R4
  wr_full_hold_chk: assert property (@(posedge wrClk) disable iff (rstAll)
    (wrEn && full) |=> $stable(wrPtr));
  // R4
  rd_empty_hold_chk: assert property (@(posedge rdClk) disable iff (rstAll)
    (rdEn && memEmpty) |=> $stable(rdPtr));
  // R1
  occupancy_bound_chk: assert property (@(posedge wrClk) disable iff (rstAll)
    wrUsed <= PW'(DEPTH));
  // R1
  gray_step_chk: assert property (@(posedge rdClk) disable iff (rstAll)
    $countones(wrGraySync ^ $past(wrGraySync)) <= 1);
  // R6
  full_af_chk: assert property (@(posedge wrClk) disable iff (rstAll)
    full |-> almostFull);
  // R5
  empty_ae_chk: assert property (@(posedge rdClk) disable iff (rstAll)
    (memEmpty && !outValid) |-> almostEmpty);
endmodule

// File: rtl/xfifo_dpath.sv
module xfifo_dpath
  import xfifo_pkg::*;
#(
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  fifoStrb_t         strb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.wrPush) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (strb.rdLoad) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/xfifo_top.sv
module xfifo_top
  import xfifo_pkg::*;
#(
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              masterRst,
  input  logic              partialRst,
  input  logic              modeSel,
  input  logic [1:0]        offSel,
  input  logic              offLoad,
  input  logic              offSerial,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFlag,
  output logic              almostFull,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdFlag,
  output logic              almostEmpty
);
  fifoStrb_t     strb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          fwftOn;

  xfifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
    .modeSel(modeSel), .offSel(offSel), .offLoad(offLoad), .offSerial(offSerial),
    .offLoData(wrData[AW-1:0]), .offHiData(wrData[HI_FIELD +: AW]),
    .wrEn(wrEn), .rdEn(rdEn), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fwftOn(fwftOn), .wrFlag(wrFlag), .almostFull(almostFull),
    .rdFlag(rdFlag), .almostEmpty(almostEmpty)
  );

  xfifo_dpath #(.DEPTH(DEPTH)) dpath_i (
    .wrClk(wrClk), .rdClk(rdClk), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );

  // R3
  fwft_hold_chk: assert property (@(posedge rdClk) disable iff (masterRst || partialRst)
    (fwftOn && rdFlag && !rdEn) |=> ($stable(rdData) && rdFlag));
endmodule

// File: tb/xfifo_top_tb_top.sv
module xfifo_top_tb_top;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        masterRst = 1'b1, partialRst = 1'b0, modeSel = 1'b0;
  logic [1:0]  offSel = 2'd0;
  logic        offLoad = 1'b0, offSerial = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [35:0] wrData = '0;
  logic        wrFlag, almostFull, rdFlag, almostEmpty;
  logic [35:0] rdData;

  int total = 0, bad = 0;
  logic [35:0] exp[$];
  bit drainOn = 0, pend = 0, fwftB = 0, manRd = 0;

  always #5 clk = ~clk;

  xfifo_top #(.DEPTH(DEPTH)) dut_i (
    .wrClk(clk), .rdClk(clk), .masterRst(masterRst), .partialRst(partialRst),
    .modeSel(modeSel), .offSel(offSel), .offLoad(offLoad), .offSerial(offSerial),
    .wrEn(wrEn), .wrData(wrData), .wrFlag(wrFlag), .almostFull(almostFull),
    .rdEn(rdEn), .rdData(rdData), .rdFlag(rdFlag), .almostEmpty(almostEmpty)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic compareFront(input string req);
    if (exp.size() == 0) begin
      total++; bad++;
      $display("FAIL %s actual=%0h expected=<none>", req, rdData);
    end else chk(req, 64'(rdData), 64'(exp.pop_front()));
  endtask

  // monitor: sole driver of rdEn
  always @(negedge clk) begin
    if (drainOn) begin
      if (!fwftB) begin
        if (pend) compareFront("R1 R2 classic order");
        if (!rdFlag) begin rdEn = 1'b1; pend = 1'b1; end
        else begin rdEn = 1'b0; pend = 1'b0; end
      end else begin
        if (rdFlag) begin compareFront("R1 R3 fall-through order"); rdEn = 1'b1; end
        else rdEn = 1'b0;
      end
    end else begin
      rdEn = manRd;
      pend = 1'b0;
    end
  end

  // driver: one word per cycle; scoreboard only gets words the block can take
  task automatic writeN(input int n, input logic [35:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b1;
      wrData = base + 36'(i);
      if (fwftB ? wrFlag : !wrFlag) exp.push_back(wrData);
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startDrain();
    @(posedge clk); drainOn = 1'b1;
  endtask

  task automatic endDrain();
    while (exp.size() != 0) @(negedge clk);
    idle(6);
    @(posedge clk); drainOn = 1'b0;
    idle(2);
  endtask

  task automatic doMaster(input bit fw, input logic [1:0] sel);
    @(negedge clk);
    modeSel = fw; offSel = sel; masterRst = 1'b1; fwftB = fw;
    exp.delete();
    idle(4);
    masterRst = 1'b0;
    idle(2);
  endtask

  task automatic finish();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    // classic mode, default offsets 8
    doMaster(1'b0, 2'd0);
    chk("R2 R10 reset empty flag", rdFlag, 1);
    chk("R2 reset full flag", wrFlag, 0);
    chk("R5 reset almostEmpty", almostEmpty, 1);
    chk("R6 reset almostFull", almostFull, 0);

    writeN(8, 36'h1_0000_0000); idle(5);
    chk("R7 count 8 at offset 8 almostEmpty", almostEmpty, 1);
    chk("R2 not empty", rdFlag, 0);
    writeN(1, 36'h1_0000_0100); idle(5);
    chk("R7 count 9 above offset 8", almostEmpty, 0);
    startDrain(); endDrain();
    chk("R2 empty after drain", rdFlag, 1);

    // R11: concurrent writes and reads on the shared clock
    startDrain();
    writeN(40, 36'hA_5A5A_0000);
    endDrain();

    // fill: almost-full boundary, full, ignored write
    writeN(247, 36'h2_0000_0000);
    chk("R6 free 9 not almostFull", almostFull, 0);
    writeN(1, 36'h2_0000_1000);
    chk("R6 free 8 almostFull", almostFull, 1);
    writeN(8, 36'h2_0000_2000);
    chk("R2 full flag", wrFlag, 1);
    writeN(1, 36'hF_DEAD_BEEF);
    chk("R4 still full after ignored write", wrFlag, 1);
    startDrain(); endDrain();
    chk("R1 all words returned", exp.size(), 0);

    // read while empty
    @(posedge clk); manRd = 1'b1;
    idle(3);
    @(posedge clk); manRd = 1'b0;
    idle(2);
    chk("R4 still empty after empty reads", rdFlag, 1);
    writeN(1, 36'h3_1234_5678); idle(5);
    chk("R4 one word after empty reads", rdFlag, 0);
    startDrain(); endDrain();

    // R8 parallel load: empty offset 3, full offset 5
    @(negedge clk); offLoad = 1'b1; offSerial = 1'b0; wrData = (36'd5 << 16) | 36'd3;
    @(negedge clk); offLoad = 1'b0;
    idle(5);
    chk("R8 no word written during load", rdFlag, 1);
    writeN(3, 36'h4_0000_0000); idle(5);
    chk("R8 count 3 at loaded offset", almostEmpty, 1);
    writeN(1, 36'h4_0000_0010); idle(5);
    chk("R8 count 4 above loaded offset", almostEmpty, 0);

    // R9 partial reset keeps offsets and mode
    @(negedge clk); partialRst = 1'b1; exp.delete();
    idle(3); partialRst = 1'b0; idle(2);
    chk("R9 empty after partial reset", rdFlag, 1);
    chk("R9 not full after partial reset", wrFlag, 0);
    writeN(3, 36'h5_0000_0000); idle(5);
    chk("R9 offset 3 kept", almostEmpty, 1);
    writeN(1, 36'h5_0000_0010); idle(5);
    chk("R9 offset 3 kept, count 4", almostEmpty, 0);
    startDrain(); endDrain();

    // R8 serial load {full=30, empty=20}, MSB first
    begin
      logic [15:0] sv;
      sv = {8'd30, 8'd20};
      for (int i = 15; i >= 0; i--) begin
        @(negedge clk); offLoad = 1'b1; offSerial = 1'b1; wrData = 36'(sv[i]);
      end
      @(negedge clk); offLoad = 1'b0; offSerial = 1'b0;
    end
    writeN(20, 36'h6_0000_0000); idle(5);
    chk("R8 serial empty offset 20 at count 20", almostEmpty, 1);
    writeN(1, 36'h6_0000_0100); idle(5);
    chk("R8 serial empty offset 20 at count 21", almostEmpty, 0);
    writeN(205, 36'h6_0001_0000);
    chk("R8 serial full offset 30 at free 30", almostFull, 1);
    startDrain(); endDrain();

    // R10: master reset restores defaults, fall-through, offsets 16
    doMaster(1'b1, 2'd1);
    chk("R3 output not ready after reset", rdFlag, 0);
    chk("R3 input ready after reset", wrFlag, 1);
    writeN(1, 36'h7_CAFE_0001); idle(6);
    chk("R3 first word ready without read enable", rdFlag, 1);
    chk("R3 first word on output", rdData, 36'h7_CAFE_0001);
    writeN(15, 36'h7_0000_0000); idle(5);
    chk("R7 R10 count 16 at default 16", almostEmpty, 1);
    writeN(1, 36'h7_0000_0100); idle(5);
    chk("R7 R10 count 17 above 16", almostEmpty, 0);
    startDrain(); endDrain();
    chk("R3 output not ready when drained", rdFlag, 0);

    // R11 in fall-through mode
    startDrain();
    writeN(50, 36'h8_0000_0000);
    endDrain();

    // R7 code 2 gives 64
    doMaster(1'b0, 2'd2);
    writeN(64, 36'h9_0000_0000); idle(5);
    chk("R7 count 64 at default 64", almostEmpty, 1);
    writeN(1, 36'h9_0000_1000); idle(5);
    chk("R7 count 65 above 64", almostEmpty, 0);
    startDrain(); endDrain();

    finish();
  end
endmodule